// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This peripheral guards a system against software that stops making progress. A 16-bit counter counts down on a slow tick. Software must keep rewriting the counter before it runs out. If the counter runs out, the block raises an interrupt, a fixed-length reset pulse, or both. Each of these outputs is gated by its own enable bit. After an expiry the counter reloads itself from a reload register and keeps counting.

The tick is made in two stages. The first is an 8-bit programmable prescaler that divides the clock by its value plus one. The second is a fixed divider of 16, 32, 64 or 128, chosen by two control bits. Software reaches the block through a simple word-addressed read/write port with four registers:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | reload data |
| 0x08 | live counter |
| 0x0C | interrupt acknowledge |

The address bits below bit 2 are ignored.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0x8039 (prescale 0x80, divider code 11, timer running, reset output enabled, interrupt disabled). The reload and counter registers read 0x8000. Both outputs are low.
- R2: Registers are selected by address bits [3:2]: 0 is control, 1 is reload data, 2 is the counter, 3 is the interrupt acknowledge. Writes to control and reload data read back unchanged in bits [15:0]. The acknowledge register always reads 0.
- R3: Control layout: bit 0 is reset enable, bit 2 is interrupt enable, bit 5 is run, bits [4:3] select the divider (00 gives 16, 01 gives 32, 10 gives 64, 11 gives 128), and bits [15:8] hold the prescale value P. One count tick occurs every (P+1) times the divider clocks.
- R4: A tick that finds the counter at zero is an expiry. The counter reloads from the reload register and keeps counting. After a counter write of N with the tick phase restarted, the expiry lands on the (N+1)-th tick.
- R5: An expiry with interrupt enable set drives the interrupt output high. It stays high until 1 is written to bit 0 of the acknowledge register. Writing 0 there leaves it high.
- R6: An expiry with reset enable set produces a reset output pulse exactly RST_PULSE_LEN (default 128) clocks long. With reset enable clear, no pulse is produced.
- R7: With the run bit clear, the counter holds its value and no expiry, interrupt or reset pulse occurs.
- R8: A counter write loads the value at the next edge. It wins over a decrement or an expiry due in the same cycle.
- R9: Every control write restarts the prescaler and the divider from zero, so the first tick follows that write by a full tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 4 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irqOut | output | 1 | Expiry interrupt, a level held until acknowledged |
| rstPulseOut | output | 1 | System reset pulse |

## Verification
Most internal faults show up as a change in when the interrupt rises after a control write. Examples are a prescaler that does not restart, a wrong divider decode, or a counter that expires on the wrong tick. Each such fault shifts the rise by a whole number of tick periods, so every divider and prescale pairing is checked by counting cycles exactly. A wrong reload or a lost service write shows as a wrong counter readback on the cycle after the event. A bad pulse counter shows as a reset pulse whose width is off by at least one clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 8;
  localparam int CTRL_W = 16;
  localparam int DIV_W  = 7;

  localparam int BIT_RST_EN = 0;
  localparam int BIT_IRQ_EN = 2;
  localparam int BIT_DIV_LO = 3;
  localparam int BIT_RUN    = 5;
  localparam int BIT_PRE_LO = 8;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h8039;
  localparam logic [CNT_W-1:0]  CNT_RESET  = 16'h8000;

  typedef struct packed {
    logic             ctrlWr;
    logic             cntWr;
    logic             clrIrq;
    logic [CNT_W-1:0] cntVal;
  } wdog_strobe_t;

  typedef struct packed {
    logic             run;
    logic             rstEn;
    logic             irqEn;
    logic [1:0]       divSel;
    logic [PRE_W-1:0] prescale;
    logic [CNT_W-1:0] reload;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  curCount,
  output logic [DATA_W-1:0] rdData,
  output wdog_strobe_t      strb,
  output wdog_cfg_t         cfg
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_ACK  = 2'd3;

  logic [1:0]        regSel;
  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  reloadReg;

  assign regSel = addr[3:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= CTRL_RESET;
      reloadReg <= CNT_RESET;
    end else if (wrEn) begin
      if (regSel == SEL_CTRL) ctrlReg   <= wrData[CTRL_W-1:0];
      if (regSel == SEL_DATA) reloadReg <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.ctrlWr = wrEn && (regSel == SEL_CTRL);
    strb.cntWr  = wrEn && (regSel == SEL_CNT);
    strb.clrIrq = wrEn && (regSel == SEL_ACK) && wrData[0];
    strb.cntVal = wrData[CNT_W-1:0];
  end

  always_comb begin
    cfg.run      = ctrlReg[BIT_RUN];
    cfg.rstEn    = ctrlReg[BIT_RST_EN];
    cfg.irqEn    = ctrlReg[BIT_IRQ_EN];
    cfg.divSel   = ctrlReg[BIT_DIV_LO +: 2];
    cfg.prescale = ctrlReg[BIT_PRE_LO +: PRE_W];
    cfg.reload   = reloadReg;
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_CTRL: rdData[CTRL_W-1:0] = ctrlReg;
      SEL_DATA: rdData[CNT_W-1:0]  = reloadReg;
      SEL_CNT:  rdData[CNT_W-1:0]  = curCount;
      default:  rdData = '0;
    endcase
  end

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_ACK) |-> (rdData == '0)); // R2
  AST_CTRL_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> (ctrlReg == $past(wrData[CTRL_W-1:0]))); // R2
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int RST_PULSE_LEN = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdog_strobe_t     strb,
  input  wdog_cfg_t        cfg,
  output logic [CNT_W-1:0] curCount,
  output logic             irqOut,
  output logic             rstOut
);
  localparam int PULSE_W = $clog2(RST_PULSE_LEN + 1);
  localparam int DIV_OPTS = 4;

  logic [PRE_W-1:0]   preCnt;
  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divTab [DIV_OPTS];
  logic [DIV_W-1:0]   divLast;
  logic [PULSE_W-1:0] pulseCnt;
  logic               preHit;
  logic               tick;
  logic               expire;

  for (genvar g = 0; g < DIV_OPTS; g++) begin : g_divTab
    assign divTab[g] = DIV_W'((16 << g) - 1);
  end

  assign divLast = divTab[cfg.divSel];
  assign preHit  = cfg.run && (preCnt == cfg.prescale);
  assign tick    = preHit && (divCnt == divLast);
  assign expire  = tick && (curCount == '0) && !strb.cntWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (strb.ctrlWr) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (cfg.run) begin
      preCnt <= preHit ? '0 : preCnt + 1'b1;
      if (preHit) divCnt <= (divCnt == divLast) ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            curCount <= CNT_RESET;
    else if (strb.cntWr)  curCount <= strb.cntVal;
    else if (tick)        curCount <= (curCount == '0) ? cfg.reload : curCount - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     irqOut <= 1'b0;
    else if (expire && cfg.irqEn)  irqOut <= 1'b1;
    else if (strb.clrIrq)          irqOut <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     pulseCnt <= '0;
    else if (expire && cfg.rstEn)  pulseCnt <= PULSE_W'(RST_PULSE_LEN);
    else if (pulseCnt != '0)       pulseCnt <= pulseCnt - 1'b1;
  end

  assign rstOut = (pulseCnt != '0);

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divLast); // R3
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    (tick && curCount == '0 && !strb.cntWr) |=> (curCount == $past(cfg.reload))); // R4
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strb.clrIrq) |=> irqOut); // R5
  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstOut) |-> $past(cfg.rstEn)); // R6
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !strb.cntWr) |=> $stable(curCount)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntWr |=> (curCount == $past(strb.cntVal))); // R8
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> (divCnt == '0)); // R9
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int RST_PULSE_LEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstPulseOut
);
  wdog_strobe_t     strb;
  wdog_cfg_t        cfg;
  logic [CNT_W-1:0] curCount;

  wdog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .curCount(curCount), .rdData(rdData), .strb(strb), .cfg(cfg)
  );

  wdog_datapath #(.RST_PULSE_LEN(RST_PULSE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg),
    .curCount(curCount), .irqOut(irqOut), .rstOut(rstPulseOut)
  );
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  localparam int NV = 5;
  localparam logic [3:0] A_CTRL = 4'h0, A_DATA = 4'h4, A_CNT = 4'h8, A_ACK = 4'hC;
  localparam int VPRE [NV] = '{0, 1, 2, 0, 4};
  localparam int VDIV [NV] = '{0, 1, 2, 3, 0};
  localparam int VCNT [NV] = '{3, 2, 0, 1, 5};
  localparam int VEXP [NV] = '{64, 192, 192, 256, 480};

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut, rstPulseOut;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  wdog_timer u_wdog_timer (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .rstPulseOut(rstPulseOut));

  function automatic logic [31:0] mk(int pre, int dv, bit run, bit ie, bit re);
    return {16'h0, 8'(pre), 2'b00, run, 2'(dv), ie, 1'b0, re};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1; wrEn = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdData;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irqOut && n < 20000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h8039);
    rd(A_DATA, v); check("R1 reload", v, 32'h8000);
    rd(A_CNT, v);  check("R1 count", v, 32'h8000);
    check("R1 irq", irqOut, 0);
    check("R1 rst", rstPulseOut, 0);
    rd(A_ACK, v);  check("R2 ack reads zero", v, 0);

    // R3/R4 vector table: cycles from control write to interrupt
    wr(A_DATA, 32'h1234);
    rd(A_DATA, v); check("R2 reload readback", v, 32'h1234);
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, mk(0, 0, 0, 0, 0));
      wr(A_ACK, 1);
      wr(A_CNT, VCNT[i]);
      wr(A_CTRL, mk(VPRE[i], VDIV[i], 1, 1, 0));
      waitIrq(n);
      check($sformatf("R3 R4 vector %0d expiry cycle", i), n, VEXP[i]);
      check("R6 no pulse when disabled", rstPulseOut, 0);
      rd(A_CNT, v); check("R4 reload after expiry", v, 32'h1234);
    end
    rd(A_CTRL, v); check("R2 ctrl readback", v, mk(4, 0, 1, 1, 0));

    // R5 acknowledge
    wr(A_CTRL, mk(0, 0, 0, 1, 0));
    wr(A_ACK, 0); check("R5 ack with 0 ignored", irqOut, 1);
    wr(A_ACK, 1); check("R5 ack with 1 clears", irqOut, 0);

    // R7 freeze
    wr(A_CNT, 2);
    repeat (200) @(posedge clk);
    #1 rd(A_CNT, v); check("R7 count frozen", v, 2);
    check("R7 no irq", irqOut, 0);

    // R8 write on a tick edge wins
    wr(A_CNT, 5);
    wr(A_CTRL, mk(0, 0, 1, 1, 0));
    repeat (15) @(posedge clk);
    wr(A_CNT, 7);
    rd(A_CNT, v); check("R8 write beats decrement", v, 7);

    // R9 control rewrite restarts tick phase
    wr(A_CTRL, mk(0, 0, 0, 1, 0));
    wr(A_CNT, 0);
    wr(A_CTRL, mk(0, 0, 1, 1, 0));
    repeat (10) @(posedge clk);
    wr(A_CTRL, mk(0, 0, 1, 1, 0));
    waitIrq(n); check("R9 phase restart", n, 16);

    // R6 reset pulse width, interrupt stays off
    wr(A_CTRL, mk(0, 0, 0, 0, 0));
    wr(A_ACK, 1);
    wr(A_DATA, 32'h100);
    wr(A_CNT, 0);
    wr(A_CTRL, mk(0, 0, 1, 0, 1));
    n = 0;
    while (!rstPulseOut && n < 1000) begin @(posedge clk); #1; n++; end
    check("R6 pulse start", n, 16);
    n = 0;
    while (rstPulseOut && n < 1000) begin @(posedge clk); #1; n++; end
    check("R6 pulse width", n, 128);
    check("R5 irq off when disabled", irqOut, 0);

    // R8 servicing keeps it quiet
    wr(A_CTRL, mk(0, 0, 1, 1, 1));
    for (int k = 0; k < 10; k++) begin
      repeat (30) @(posedge clk);
      wr(A_CNT, 2);
    end
    check("R8 serviced no irq", irqOut, 0);
    check("R8 serviced no pulse", rstPulseOut, 0);
    finishRun();
  end
endmodule